// File: doc/BRIEF.md
# Single-Accumulator Processor Core

This block is a small processor that keeps every intermediate result in one 16-bit accumulator. Each 16-bit instruction word carries a 4-bit opcode in bits 15..12 and a 12-bit operand in bits 11..0. The operand is a word address into a 4096-word memory, a branch target, or an immediate value, depending on the opcode. Data is treated as two's complement with bit 15 as the sign. Four condition flags record the last result: negative (N), zero (Z), signed overflow (V) and carry (C).

The core connects to one word-wide memory port. Reads are combinational: data for `mem_addr_o` is valid in the same cycle. Writes take effect at the rising clock edge while `mem_we_o` is high. Every instruction takes two cycles. In the fetch cycle the PC is placed on the port, the instruction word is captured and the PC is incremented. In the execute cycle the operand address is placed on the port and the instruction takes effect. A halt instruction stops the core until reset. The PC, accumulator and flags are visible on debug outputs.

Top module: `acc_core`

## Requirements
- R1: While `rst_ni` is low, `dbg_pc_o`, `dbg_acc_o` and `dbg_flags_o` are 0 and `halt_o` is 0. The core starts fetching at address 0.
- R2: Every non-halt instruction takes exactly two clock cycles. A program of k instructions that ends in halt raises `halt_o` 2·k rising edges after reset is released. Without a taken jump or branch, the PC advances by one per instruction. `dbg_pc_o` increments at the fetch edge.
- R3: Opcode 0x0 (load) copies the memory word at the operand address into the accumulator. It sets N from bit 15 and Z from an all-zero value, and leaves V and C unchanged.
- R4: Opcode 0x1 (add) sets the accumulator to accumulator + memory word. C is the carry out of bit 15. V is set when the signed sum falls outside −32768..32767. N and Z follow the result.
- R5: Opcode 0x4 (subtract) sets the accumulator to accumulator − memory word. C is 1 when no borrow occurs (unsigned accumulator ≥ memory word). V marks signed overflow. N and Z follow the result.
- R6: Opcode 0x2 (store) writes the accumulator to the operand address during the execute cycle. The accumulator is unchanged, N and Z are taken from it, and V and C are kept. `mem_we_o` is high in no other cycle.
- R7: Opcode 0x5 (load immediate) loads the 12-bit operand, zero-extended, into the accumulator. N and Z are updated and V and C are kept.
- R8: Opcode 0x3 (branch if greater than zero) loads the PC from the operand when N and Z are both 0. Otherwise execution continues in sequence. Flags and accumulator are unchanged.
- R9: Opcode 0x6 (jump) always loads the PC from the operand. Flags and accumulator are unchanged.
- R10: Opcode 0x7 (halt) raises `halt_o`, which stays high until reset. From then on the PC (left at the halt address + 1) and the accumulator stay fixed, and no memory write occurs.
- R11: Opcodes 0x8 to 0xF do nothing. Accumulator and flags are kept and the PC advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 12 | Word address: the PC in fetch, the operand in execute |
| mem_we_o | output | 1 | Write strobe for a store |
| mem_wdata_o | output | 16 | Write data (the accumulator) |
| mem_rdata_i | input | 16 | Combinational read data for `mem_addr_o` |
| halt_o | output | 1 | High once a halt instruction has executed |
| dbg_pc_o | output | 12 | Program counter |
| dbg_acc_o | output | 16 | Accumulator |
| dbg_flags_o | output | 4 | Flags {N, Z, V, C} |

## Verification
The bench builds the core with its default parameters: 16-bit data, 12-bit addresses and 4-bit opcodes. This makes the full 4096-word address space and the true sign and carry boundaries at 0x7FFF/0x8000 and 0xFFFF/0x0000 reachable. Directed programs push add and subtract across those boundaries and run a counted branch loop down to zero. Random straight-line programs over a small data window are compared with a bench instruction-level model on final accumulator, flags, PC, cycle count and memory contents.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;
  localparam logic [3:0] OP_LOAD  = 4'h0;
  localparam logic [3:0] OP_ADD   = 4'h1;
  localparam logic [3:0] OP_STORE = 4'h2;
  localparam logic [3:0] OP_BGT   = 4'h3;
  localparam logic [3:0] OP_SUB   = 4'h4;
  localparam logic [3:0] OP_LDI   = 4'h5;
  localparam logic [3:0] OP_JMP   = 4'h6;
  localparam logic [3:0] OP_HALT  = 4'h7;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  typedef enum logic {ST_FETCH = 1'b0, ST_EXEC = 1'b1} state_e;
endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_core_pkg::*;
#(
  parameter int DW  = 16,
  parameter int OPW = 4
) (
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0]  acc_i,
  input  logic [DW-1:0]  mdata_i,
  input  logic [DW-1:0]  imm_i,
  input  flags_t         flags_i,
  output logic [DW-1:0]  res_o,
  output flags_t         flags_o,
  output logic           acc_we_o
);
  localparam int MSB = DW - 1;

  logic [DW:0] sum, diff;

  assign sum  = {1'b0, acc_i} + {1'b0, mdata_i};
  assign diff = {1'b0, acc_i} + {1'b0, ~mdata_i} + (DW+1)'(1);

  always_comb begin
    res_o    = acc_i;
    flags_o  = flags_i;
    acc_we_o = 1'b0;
    case (op_i)
      OP_LOAD: begin
        res_o    = mdata_i;
        acc_we_o = 1'b1;
      end
      OP_ADD: begin
        res_o     = sum[DW-1:0];
        acc_we_o  = 1'b1;
        flags_o.c = sum[DW];
        flags_o.v = (acc_i[MSB] == mdata_i[MSB]) && (sum[MSB] != acc_i[MSB]);
      end
      OP_SUB: begin
        res_o     = diff[DW-1:0];
        acc_we_o  = 1'b1;
        flags_o.c = diff[DW];
        flags_o.v = (acc_i[MSB] != mdata_i[MSB]) && (diff[MSB] != acc_i[MSB]);
      end
      OP_LDI: begin
        res_o    = imm_i;
        acc_we_o = 1'b1;
      end
      default: ;
    endcase
    // N/Z follow every value that is moved or computed, store included
    if (acc_we_o || op_i == OP_STORE) begin
      flags_o.n = res_o[MSB];
      flags_o.z = (res_o == '0);
    end
  end
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_core_pkg::*;
#(
  parameter int AW  = 12,
  parameter int OPW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [OPW-1:0] op_i,
  input  logic [AW-1:0]  target_i,
  input  logic           flag_n_i,
  input  logic           flag_z_i,
  output logic           fetch_o,
  output logic           exec_o,
  output logic [AW-1:0]  pc_o,
  output logic           halted_o
);
  state_e state_q;

  assign fetch_o = (state_q == ST_FETCH) && !halted_o;
  assign exec_o  = (state_q == ST_EXEC)  && !halted_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_FETCH;
      pc_o     <= '0;
      halted_o <= 1'b0;
    end else if (!halted_o) begin
      if (state_q == ST_FETCH) begin
        pc_o    <= pc_o + AW'(1);
        state_q <= ST_EXEC;
      end else begin
        state_q <= ST_FETCH;
        case (op_i)
          OP_JMP:  pc_o <= target_i;
          OP_BGT:  if (!flag_n_i && !flag_z_i) pc_o <= target_i;
          OP_HALT: halted_o <= 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int AW  = 12,
  parameter int OPW = 4,
  localparam int DW = AW + OPW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          halt_o,
  output logic [AW-1:0] dbg_pc_o,
  output logic [DW-1:0] dbg_acc_o,
  output logic [3:0]    dbg_flags_o
);
  logic [DW-1:0]  ir, acc_q, alu_res;
  logic [OPW-1:0] op;
  logic [AW-1:0]  operand, pc;
  flags_t         flags_q, alu_flags;
  logic           fetch, exec, alu_acc_we, halted;

  assign op      = ir[DW-1:AW];
  assign operand = ir[AW-1:0];

  acc_ctrl #(.AW(AW), .OPW(OPW)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op),
    .target_i (operand),
    .flag_n_i (flags_q.n),
    .flag_z_i (flags_q.z),
    .fetch_o  (fetch),
    .exec_o   (exec),
    .pc_o     (pc),
    .halted_o (halted)
  );

  acc_alu #(.DW(DW), .OPW(OPW)) u_alu (
    .op_i     (op),
    .acc_i    (acc_q),
    .mdata_i  (mem_rdata_i),
    .imm_i    (DW'(operand)),
    .flags_i  (flags_q),
    .res_o    (alu_res),
    .flags_o  (alu_flags),
    .acc_we_o (alu_acc_we)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir      <= '0;
      acc_q   <= '0;
      flags_q <= '0;
    end else if (fetch) begin
      ir <= mem_rdata_i;
    end else if (exec) begin
      flags_q <= alu_flags;
      if (alu_acc_we) acc_q <= alu_res;
    end
  end

  assign mem_addr_o  = exec ? operand : pc;
  assign mem_we_o    = exec && (op == OP_STORE);
  assign mem_wdata_o = acc_q;
  assign halt_o      = halted;
  assign dbg_pc_o    = pc;
  assign dbg_acc_o   = acc_q;
  assign dbg_flags_o = flags_q;
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk
  import acc_core_pkg::*;
#(
  parameter int AW  = 12,
  parameter int OPW = 4,
  parameter int DW  = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_we_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          halt_o,
  input logic [AW-1:0] dbg_pc_o,
  input logic [DW-1:0] dbg_acc_o,
  input logic [3:0]    dbg_flags_o,
  input logic          exec_i,
  input logic [DW-1:0] ir_i
);
  logic [OPW-1:0] op;
  assign op = ir_i[DW-1:AW];

  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i |-> dbg_pc_o == $past(dbg_pc_o) + AW'(1)); // R2

  AST_LOAD_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(exec_i && op == OP_LOAD) |-> (dbg_flags_o[3] == dbg_acc_o[DW-1]) &&
      (dbg_flags_o[2] == (dbg_acc_o == '0)) && (dbg_flags_o[1:0] == $past(dbg_flags_o[1:0]))); // R3

  AST_STORE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> exec_i && op == OP_STORE && mem_wdata_o == dbg_acc_o); // R6

  AST_BGT_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(exec_i && op == OP_BGT && !dbg_flags_o[3] && !dbg_flags_o[2]) |->
      dbg_pc_o == $past(ir_i[AW-1:0])); // R8

  AST_JMP_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(exec_i && op == OP_JMP) |-> dbg_pc_o == $past(ir_i[AW-1:0]) && $stable(dbg_acc_o)); // R9

  AST_HALT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o && $stable(dbg_pc_o) && $stable(dbg_acc_o)); // R10

  AST_HALT_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> !mem_we_o); // R10

  AST_NOP_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(exec_i && op[OPW-1]) |-> $stable(dbg_acc_o) && $stable(dbg_flags_o)); // R11
endmodule

bind acc_core acc_core_chk #(.AW(AW), .OPW(OPW), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_we_o    (mem_we_o),
  .mem_wdata_o (mem_wdata_o),
  .halt_o      (halt_o),
  .dbg_pc_o    (dbg_pc_o),
  .dbg_acc_o   (dbg_acc_o),
  .dbg_flags_o (dbg_flags_o),
  .exec_i      (exec),
  .ir_i        (ir)
);

// File: tb/acc_core_tb_top.sv
`timescale 1ns/1ps
module acc_core_tb_top;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int MEM_WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          halt;
  logic [AW-1:0] dbg_pc;
  logic [DW-1:0] dbg_acc;
  logic [3:0]    dbg_flags;

  logic [DW-1:0] mem     [MEM_WORDS];
  logic [DW-1:0] ref_mem [MEM_WORDS];
  logic [DW-1:0] img     [MEM_WORDS];

  int n_checks = 0, n_fail = 0, wr_in_halt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  acc_core dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .mem_addr_o(mem_addr), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .halt_o(halt),
    .dbg_pc_o(dbg_pc), .dbg_acc_o(dbg_acc), .dbg_flags_o(dbg_flags)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (rst_ni && halt && mem_we) wr_in_halt++;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(logic [3:0] op, logic [11:0] a);
    return {op, a};
  endfunction

  // instruction-level model, flags {N,Z,V,C}
  task automatic ref_run(output logic [15:0] acc, output logic [3:0] fl,
                         output logic [11:0] pc, output int steps);
    logic [15:0] ins, m;
    int sv;
    acc = '0; fl = '0; pc = '0; steps = 0;
    while (steps < 4000) begin
      ins = ref_mem[pc];
      pc = pc + 12'd1;
      steps++;
      m = ref_mem[ins[11:0]];
      case (ins[15:12])
        4'h0: begin acc = m; fl[3] = acc[15]; fl[2] = (acc == 0); end
        4'h1: begin
          sv = $signed(acc) + $signed(m);
          fl[0] = (32'(acc) + 32'(m)) > 32'hFFFF;
          fl[1] = (sv > 32767) || (sv < -32768);
          acc = acc + m; fl[3] = acc[15]; fl[2] = (acc == 0);
        end
        4'h4: begin
          sv = $signed(acc) - $signed(m);
          fl[0] = (acc >= m);
          fl[1] = (sv > 32767) || (sv < -32768);
          acc = acc - m; fl[3] = acc[15]; fl[2] = (acc == 0);
        end
        4'h2: begin ref_mem[ins[11:0]] = acc; fl[3] = acc[15]; fl[2] = (acc == 0); end
        4'h5: begin acc = {4'h0, ins[11:0]}; fl[3] = 1'b0; fl[2] = (acc == 0); end
        4'h3: if (!fl[3] && !fl[2]) pc = ins[11:0];
        4'h6: pc = ins[11:0];
        4'h7: break;
        default: ;
      endcase
    end
  endtask

  task automatic clear_img();
    for (int i = 0; i < MEM_WORDS; i++) img[i] = '0;
  endtask

  // runs img on DUT and model, compares everything
  task automatic run_prog(string tag);
    logic [15:0] e_acc;
    logic [3:0]  e_fl;
    logic [11:0] e_pc;
    int steps, cyc;
    @(negedge clk);
    rst_ni = 1'b0;
    for (int i = 0; i < MEM_WORDS; i++) begin mem[i] = img[i]; ref_mem[i] = img[i]; end
    @(negedge clk);
    check({"R1 pc ", tag}, 32'(dbg_pc), 0);
    check({"R1 acc ", tag}, 32'(dbg_acc), 0);
    check({"R1 flags ", tag}, 32'(dbg_flags), 0);
    check({"R1 halt ", tag}, 32'(halt), 0);
    ref_run(e_acc, e_fl, e_pc, steps);
    rst_ni = 1'b1;
    cyc = 0;
    while (!halt && cyc < 10000) begin @(negedge clk); cyc++; end
    check({"R2 cycles ", tag}, 32'(cyc), 32'(2 * steps));
    check({"R3-model acc ", tag}, 32'(dbg_acc), 32'(e_acc));
    check({"R4-model flags ", tag}, 32'(dbg_flags), 32'(e_fl));
    check({"R10 pc ", tag}, 32'(dbg_pc), 32'(e_pc));
    for (int a = 12'h800; a < 12'h810; a++)
      check({"R6 mem ", tag}, 32'(mem[a]), 32'(ref_mem[a]));
  endtask

  initial begin
    void'($urandom(32'h5EED_0A11));
    mem_init: for (int i = 0; i < MEM_WORDS; i++) mem[i] = '0;

    // R4 overflow to 0x8000, R6 store, R3 load keeps V/C
    clear_img();
    img[0] = enc(4'h0, 12'h800); img[1] = enc(4'h1, 12'h801);
    img[2] = enc(4'h2, 12'h802); img[3] = enc(4'h0, 12'h801);
    img[4] = enc(4'h7, 12'h000);
    img[12'h800] = 16'h7FFF; img[12'h801] = 16'h0001;
    run_prog("p1");
    check("R6 stored sum", 32'(mem[12'h802]), 32'h8000);
    check("R3 load acc", 32'(dbg_acc), 32'h0001);
    check("R3 load keeps V", 32'(dbg_flags), 32'b0010);

    // R5 borrow: 1 - 2
    clear_img();
    img[0] = enc(4'h5, 12'h001); img[1] = enc(4'h4, 12'h800); img[2] = enc(4'h7, 0);
    img[12'h800] = 16'h0002;
    run_prog("p2");
    check("R5 borrow acc", 32'(dbg_acc), 32'hFFFF);
    check("R5 borrow flags", 32'(dbg_flags), 32'b1000);

    // R5 equal operands, R7 immediate
    clear_img();
    img[0] = enc(4'h5, 12'h005); img[1] = enc(4'h4, 12'h800); img[2] = enc(4'h7, 0);
    img[12'h800] = 16'h0005;
    run_prog("p3");
    check("R5 zero flags", 32'(dbg_flags), 32'b0101);

    // R5 signed overflow: 0x8000 - 1
    clear_img();
    img[0] = enc(4'h0, 12'h800); img[1] = enc(4'h4, 12'h801); img[2] = enc(4'h7, 0);
    img[12'h800] = 16'h8000; img[12'h801] = 16'h0001;
    run_prog("p4");
    check("R5 overflow acc", 32'(dbg_acc), 32'h7FFF);
    check("R5 overflow flags", 32'(dbg_flags), 32'b0011);

    // R7 zero extension
    clear_img();
    img[0] = enc(4'h5, 12'hFFF); img[1] = enc(4'h7, 0);
    run_prog("p5");
    check("R7 ldi acc", 32'(dbg_acc), 32'h0FFF);
    check("R7 ldi flags", 32'(dbg_flags), 32'b0000);

    // R8 count-down loop
    clear_img();
    img[0] = enc(4'h0, 12'h800); img[1] = enc(4'h4, 12'h801);
    img[2] = enc(4'h3, 12'h001); img[3] = enc(4'h7, 0);
    img[12'h800] = 16'd3; img[12'h801] = 16'd1;
    run_prog("p6");
    check("R8 loop pc", 32'(dbg_pc), 32'd4);
    check("R8 loop acc", 32'(dbg_acc), 32'd0);

    // R9 jump over code, R11 no-op keeps Z
    clear_img();
    img[0] = enc(4'h5, 12'h000); img[1] = enc(4'h6, 12'h005);
    img[2] = enc(4'h5, 12'h0AB); img[5] = enc(4'hA, 12'h123);
    img[6] = enc(4'h7, 0);
    run_prog("p7");
    check("R9 jump acc", 32'(dbg_acc), 32'd0);
    check("R11 nop flags", 32'(dbg_flags), 32'b0100);
    check("R9 jump pc", 32'(dbg_pc), 32'd7);

    // R10 halt freeze
    wr_in_halt = 0;
    begin
      logic [11:0] pc_h;
      pc_h = dbg_pc;
      repeat (10) @(negedge clk);
      check("R10 pc frozen", 32'(dbg_pc), 32'(pc_h));
      check("R10 halt held", 32'(halt), 1);
      check("R10 no write", 32'(wr_in_halt), 0);
    end

    // random straight-line programs
    for (int p = 0; p < 20; p++) begin
      clear_img();
      for (int i = 0; i < 24; i++) begin
        logic [3:0] op;
        case ($urandom_range(0, 5))
          0: op = 4'h0;
          1: op = 4'h1;
          2: op = 4'h2;
          3: op = 4'h4;
          4: op = 4'h5;
          default: op = 4'(8 + $urandom_range(0, 7));
        endcase
        img[i] = (op == 4'h5) ? enc(op, 12'($urandom)) : enc(op, 12'h800 + 12'($urandom_range(0, 15)));
      end
      img[24] = enc(4'h7, 0);
      for (int a = 12'h800; a < 12'h810; a++)
        img[a] = ($urandom_range(0, 3) == 0) ? 16'h7FFF + 16'($urandom_range(0, 2)) : 16'($urandom);
      run_prog($sformatf("rnd%0d", p));
    end

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule